// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

The block turns a fast reference clock into the clocks a small processor system needs. One of two reference inputs is chosen: a crystal-derived clock or an external frequency input. The chosen reference is passed straight out as the oscillator output. A processor clock is derived at one third of that rate, and a peripheral clock at half the processor rate. An asynchronous ready input is also retimed to the processor clock, so that the processor sees a clean ready level.

The divider is a four-state machine clocked by the selected reference. `PH_HOLD` is the parked state: reset enters it, and a high `sync_in` forces it. The first reference edge that samples `sync_in` low takes `PH_HOLD` to `PH_HIGH`. The machine then cycles `PH_HIGH` to `PH_LOW_A` to `PH_LOW_B` and back to `PH_HIGH`. Any edge that samples `sync_in` high returns it to `PH_HOLD`. The processor clock is high only in `PH_HIGH`. Every move into `PH_HIGH` is a processor-clock rising edge. On that event the peripheral clock toggles and the ready pipeline shifts. When several generators share the sync line, they restart on the same reference edge and stay in phase.

The model is synchronous logic behind a plain source multiplexer. A source change is made while the block is in reset, or while it is held by sync.

Top module: `clk_div3_gen`

## Requirements
- R1: While `rst_n` is low, `proc_clk`, `periph_clk` and `rdy_out` are 0 at once, independent of any clock.
- R2: With `sync_in` low, `proc_clk` is high for exactly one of every three rising edges of the selected reference, so its period is three reference periods.
- R3: `periph_clk` changes only when `proc_clk` rises, and it toggles on every such rise, giving a period of six reference periods with a 50% duty cycle.
- R4: `osc_out` follows `xtal_clk` when `src_sel` is 0 and `ext_clk` when `src_sel` is 1, and the dividers run from that same clock.
- R5: A reference edge that samples `sync_in` high drives `proc_clk` and `periph_clk` low. The first edge that samples it low raises both together.
- R6: `rdy_out` equals `rdy_in` as it was sampled on the processor-clock rising edge before the most recent one: two stages, each advancing only on a `proc_clk` rise.
- R7: `sync_in` does not clear the ready stages, so `rdy_out` keeps its value while the divider is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-derived reference clock |
| ext_clk | input | 1 | External frequency reference clock |
| src_sel | input | 1 | Reference choice: 0 crystal, 1 external |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Holds and realigns the dividers while high |
| rdy_in | input | 1 | Asynchronous ready request |
| osc_out | output | 1 | Selected reference passed through |
| proc_clk | output | 1 | Processor clock, reference divided by three |
| periph_clk | output | 1 | Peripheral clock, processor clock divided by two |
| rdy_out | output | 1 | Ready retimed to processor-clock rises |

## Verification
A wrong divider state shows up on `proc_clk` within one reference cycle. The high pulse lands on the wrong edge or lasts more than one edge, and the period check then sees a spacing other than three reference periods. A peripheral toggle that is missed or doubled shows up on `periph_clk` at the next processor rise and flips its phase for the rest of the run. A ready stage that is clocked every reference cycle, or cleared by sync, shows up on `rdy_out` one reference edge after `rdy_in` changes, or on the edge where sync is raised.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW_A = 2'd2,
        PH_LOW_B = 2'd3
    } div_phase_t;

    localparam int unsigned DIV_RATIO = 3;
endpackage

// File: rtl/div3_fsm.sv
module div3_fsm
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic proc_clk,
    output logic rise_tick
);
    div_phase_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = PH_HOLD;
        end else begin
            unique case (state_q)
                PH_HOLD:  state_d = PH_HIGH;
                PH_HIGH:  state_d = PH_LOW_A;
                PH_LOW_A: state_d = PH_LOW_B;
                PH_LOW_B: state_d = PH_HIGH;
                default:  state_d = PH_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        proc_clk  = (state_q == PH_HIGH);
        rise_tick = (state_d == PH_HIGH);
    end

    // The high phase lasts a single reference cycle.
    p_high_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        proc_clk |=> !proc_clk);
endmodule

// File: rtl/pclk_div2.sv
module pclk_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic toggle,
    output logic pclk
);
    logic pclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pclk_q <= 1'b0;
        else if (clr)    pclk_q <= 1'b0;
        else if (toggle) pclk_q <= ~pclk_q;
    end

    assign pclk = pclk_q;

    // The peripheral clock changes only on a processor rise or a sync clear.
    p_pclk_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pclk_q) |-> ($past(toggle) || $past(clr)));
endmodule

// File: rtl/rdy_retime.sv
module rdy_retime #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            logic src;
            if (gi == 0) begin : g_first
                assign src = din;
            end else begin : g_next
                assign src = stage_q[gi-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    stage_q[gi] <= 1'b0;
                else if (step) stage_q[gi] <= src;
            end
        end
    endgenerate

    assign dout = stage_q[LAST];

    // Output moves only on processor-clock rises (R6, R7).
    p_rdy_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) |-> $stable(dout));
endmodule

// File: rtl/clk_div3_gen.sv
module clk_div3_gen #(
    parameter int unsigned RDY_STAGES = 2
) (
    input  logic xtal_clk,
    input  logic ext_clk,
    input  logic src_sel,
    input  logic rst_n,
    input  logic sync_in,
    input  logic rdy_in,
    output logic osc_out,
    output logic proc_clk,
    output logic periph_clk,
    output logic rdy_out
);
    logic ref_clk;
    logic tick;

    assign ref_clk = src_sel ? ext_clk : xtal_clk;
    assign osc_out = ref_clk;

    div3_fsm u_div3 (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .hold      (sync_in),
        .proc_clk  (proc_clk),
        .rise_tick (tick)
    );

    pclk_div2 u_pclk (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .clr    (sync_in),
        .toggle (tick),
        .pclk   (periph_clk)
    );

    rdy_retime #(.STAGES(RDY_STAGES)) u_rdy (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .step  (tick),
        .din   (rdy_in),
        .dout  (rdy_out)
    );

    p_sync_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sync_in |=> (!proc_clk && !periph_clk));

    p_restart_together_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(proc_clk) && $past(!proc_clk && !periph_clk) |-> periph_clk);
endmodule

// File: tb/clk_div3_gen_test.sv
module clk_div3_gen_test;
    localparam real XTAL_PERIOD = 10.0;
    localparam real EXT_PERIOD  = 16.0;

    logic xtal_clk = 0, ext_clk = 0, src_sel = 0, rst_n = 0, sync_in = 0, rdy_in = 0;
    logic osc_out, proc_clk, periph_clk, rdy_out;

    int checks = 0, errors = 0;
    logic [2:0] exp_q[$];
    int m_st = 0;
    logic m_pclk = 0, m_r1 = 0, m_r2 = 0;
    bit done = 0;

    always #(XTAL_PERIOD/2) xtal_clk = ~xtal_clk;
    always #(EXT_PERIOD/2)  ext_clk  = ~ext_clk;

    clk_div3_gen uut (
        .xtal_clk(xtal_clk), .ext_clk(ext_clk), .src_sel(src_sel), .rst_n(rst_n),
        .sync_in(sync_in), .rdy_in(rdy_in), .osc_out(osc_out), .proc_clk(proc_clk),
        .periph_clk(periph_clk), .rdy_out(rdy_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Driver side: expected item per reference rising edge, from R2, R3, R5, R6.
    always @(posedge osc_out) begin
        if (!rst_n) begin
            m_st = 0; m_pclk = 0; m_r1 = 0; m_r2 = 0;
            exp_q.delete();
        end else begin
            if (sync_in) begin
                m_st = 0; m_pclk = 0;
            end else begin
                m_st = (m_st == 0 || m_st == 3) ? 1 : m_st + 1;
                if (m_st == 1) begin
                    m_pclk = ~m_pclk;
                    m_r2 = m_r1;
                    m_r1 = rdy_in;
                end
            end
            exp_q.push_back({m_st == 1, m_pclk, m_r2});
        end
    end

    // Monitor side: compare away from the active edge.
    always @(negedge osc_out) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check("R2 proc_clk", proc_clk, e[2]);
            check("R3 periph_clk", periph_clk, e[1]);
            check("R6 rdy_out", rdy_out, e[0]);
        end
    end

    task automatic wait_ref(input int n);
        for (int i = 0; i < n; i++) @(negedge osc_out);
    endtask

    task automatic check_periods(input real p);
        realtime t0, t1, u0, u1;
        @(posedge proc_clk); t0 = $realtime;
        @(posedge proc_clk); t1 = $realtime;
        check("R2 proc period", int'(t1 - t0), int'(3.0 * p));
        @(posedge periph_clk); u0 = $realtime;
        @(posedge periph_clk); u1 = $realtime;
        check("R3 periph period", int'(u1 - u0), int'(6.0 * p));
        #1;
        check("R4 osc follows source", osc_out, src_sel ? ext_clk : xtal_clk);
    endtask

    initial begin
        #(XTAL_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        check("R1 reset proc", proc_clk, 0);
        check("R1 reset periph", periph_clk, 0);
        check("R1 reset rdy", rdy_out, 0);
        wait_ref(3);
        rst_n = 1;
        wait_ref(20);
        check_periods(XTAL_PERIOD);
        @(negedge osc_out); rdy_in = 1;
        wait_ref(12);
        check("R6 rdy after two rises", rdy_out, 1);
        // R5: hold, then release and look at the first edge.
        @(negedge osc_out); sync_in = 1;
        wait_ref(5);
        check("R5 held proc", proc_clk, 0);
        check("R7 rdy kept during sync", rdy_out, 1);
        sync_in = 0;
        @(posedge osc_out); #1;
        check("R5 proc up on first edge", proc_clk, 1);
        check("R5 periph up together", periph_clk, 1);
        // R6 with pulses of ready shorter than a processor period.
        for (int k = 0; k < 6; k++) begin
            @(negedge osc_out); rdy_in = k[0];
            wait_ref(k + 2);
        end
        // R4: switch source under reset.
        @(negedge osc_out); rst_n = 0;
        #1 check("R1 async reset proc", proc_clk, 0);
        check("R1 async reset rdy", rdy_out, 0);
        src_sel = 1;
        #(EXT_PERIOD * 3);
        @(negedge osc_out); rst_n = 1;
        wait_ref(15);
        check_periods(EXT_PERIOD);
        for (int k = 0; k < 4; k++) begin
            @(negedge osc_out); sync_in = 1; rdy_in = ~rdy_in;
            wait_ref(k + 1);
            sync_in = 0;
            wait_ref(7 + k);
        end
        wait_ref(10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule